// File: doc/BRIEF.md
# Composite Sync Validator and Clamp Pulse Generator

This block runs on the video sample clock. Its single input pin carries one of two signals. In composite-sync mode it carries an active-low sync signal. The block then accepts a sync tip only when two tests pass. The tip's falling edge must land inside an acceptance window placed one line period after the last accepted edge. The level must still be low when a minimum-width interval ends. From each accepted tip the block issues a fixed-width, active-high clamp pulse on the back porch. The pulse starts a set delay after the tip's rising edge. In pass-through mode the pin carries an external clamp pulse, which is copied to the clamp output.

Edges that arrive before the window opens are ignored. Short low glitches fail the width test. Neither kind moves the line reference, so noise cannot pull the line timing off its lock. The two gate signals and a one-cycle strobe for each accepted tip are brought out for the rest of the video path. The line timing for each standard is set by parameters.

Top module: `csync_clamp_gen`

## Requirements
- R1: With `clamp_en` low, `clamp_out` equals the synchronized pin level, one cycle after the synchronizer output. In this mode `gate1` is low, `gate2` is high, `sync_valid` is low, and the block returns to acquisition.
- R2: The pin passes through a two-flop synchronizer. An edge first affects the synchronized level two cycles after it is sampled, and every interval is counted in clock cycles after synchronization.
- R3: When locked, `gate1` is high while the count of cycles since the last accepted falling edge is in [A, A+B). A is 867 and B is 43 with `std_pal` low; A is 1075 and B is 61 with `std_pal` high. During acquisition `gate1` stays high.
- R4: A synchronized falling edge while `gate1` is low is ignored. `gate2` stays high, and the line count is not restarted.
- R5: A synchronized falling edge while `gate1` is high and no width test is running starts a width test. `gate2` is then low for exactly 58 cycles, starting the next cycle.
- R6: If the synchronized level is low on the last low cycle of `gate2`, the tip is accepted. `sync_valid` is high for one cycle, the block locks, the line reference becomes that tip's falling edge, and `gate1` is low in that strobe cycle. If the level is high at that point, the event is discarded.
- R7: After an accepted tip, its synchronized rising edge at cycle r makes `clamp_out` high for exactly 54 cycles, starting at cycle r+D+1. D is `CLAMP_DLY` and defaults to 8.
- R8: When locked, the block returns to acquisition once the count reaches A+B with no width test running. A width test that fails after that point also returns it to acquisition.
- R9: After reset, with `clamp_en` high, `gate1` and `gate2` are high and `clamp_out` and `sync_valid` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous active-high reset |
| clamp_en | input | 1 | 1: composite-sync mode; 0: external clamp pass-through |
| std_pal | input | 1 | Line timing select: 0 NTSC, 1 PAL |
| sync_in | input | 1 | Composite sync (active low) or external clamp pulse |
| clamp_out | output | 1 | Active-high clamp pulse |
| gate1 | output | 1 | Falling-edge acceptance window |
| gate2 | output | 1 | Low while a tip width test runs |
| sync_valid | output | 1 | One-cycle strobe per accepted tip |

## Verification
A wrong line count or lock state shows up first at `gate1`. The window opens or closes a cycle off, or does not drop on loss of lock. Once a line later, a good tip is refused, which shows up as a missing `sync_valid` and a missing clamp pulse. A fault in the width test shows at `gate2` within the 58-cycle test. It also shows at `sync_valid` in the cycle right after the test ends, for example when a short glitch is accepted. A wrong delay or pulse counter moves or resizes the clamp pulse within 62 cycles of the tip's rising edge. A cycle-accurate model comparison therefore catches each of these faults within one line.

// File: rtl/csv_pkg.sv
package csv_pkg;

  typedef enum logic {
    LS_ACQ  = 1'b0,
    LS_LOCK = 1'b1
  } lock_e;

  function automatic int csv_max(input int x, input int y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/csv_sync.sv
module csv_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic s_lvl,
  output logic s_fall,
  output logic s_rise
);

  logic [SYNC_STAGES-1:0] sh_q;
  logic                   prev_q;

  generate
    if (SYNC_STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) sh_q <= 1'b1;
        else     sh_q <= din;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[SYNC_STAGES-2:0], din};
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b1;
    else     prev_q <= sh_q[SYNC_STAGES-1];
  end

  assign s_lvl  = sh_q[SYNC_STAGES-1];
  assign s_fall = prev_q & ~s_lvl;
  assign s_rise = ~prev_q & s_lvl;

  logic [1:0] warm_q;
  always_ff @(posedge clk) begin
    if (rst)              warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 2'd1;
  end

  generate
    if (SYNC_STAGES == 2) begin : g_chk
      // R2: synchronized level trails the pin by two edges
      p_sync_lat_r2: assert property (@(posedge clk) disable iff (rst)
        (warm_q == 2'd3) |-> (s_lvl == $past(din, 2)));
    end
  endgenerate

endmodule

// File: rtl/csv_line.sv
module csv_line
  import csv_pkg::*;
#(
  parameter int A_NTSC = 867,
  parameter int B_NTSC = 43,
  parameter int A_PAL  = 1075,
  parameter int B_PAL  = 61,
  parameter int TIP_W  = 58,
  parameter int LCW    = 11,
  parameter int QW     = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic pal,
  input  logic s_lvl,
  input  logic s_fall,
  output logic gate1,
  output logic gate2,
  output logic valid
);

  localparam logic [LCW-1:0] A_NC   = LCW'(A_NTSC);
  localparam logic [LCW-1:0] E_NC   = LCW'(A_NTSC + B_NTSC);
  localparam logic [LCW-1:0] A_PC   = LCW'(A_PAL);
  localparam logic [LCW-1:0] E_PC   = LCW'(A_PAL + B_PAL);
  localparam logic [LCW-1:0] ACC_LC = LCW'(TIP_W + 1);
  localparam logic [QW-1:0]  TIP_C  = QW'(TIP_W);

  lock_e          lock_q, lock_n;
  logic [LCW-1:0] lc_q, lc_n, lc_inc, a_v, e_v;
  logic           busy_q, busy_n;
  logic [QW-1:0]  q_q, q_n;
  logic           win, expire;
  logic           g1_q, g2_q, val_q, g1_n, g2_n, val_n;

  always_comb begin
    a_v    = pal ? A_PC : A_NC;
    e_v    = pal ? E_PC : E_NC;
    lc_inc = (&lc_q) ? lc_q : lc_q + 1'b1;
    win    = (lock_q == LS_ACQ) || (lc_q >= a_v && lc_q < e_v);
    expire = (lock_q == LS_LOCK) && (lc_inc >= e_v);

    lock_n = lock_q;
    lc_n   = lc_inc;
    busy_n = busy_q;
    q_n    = q_q;
    val_n  = 1'b0;

    if (!en) begin
      lock_n = LS_ACQ;
      lc_n   = '0;
      busy_n = 1'b0;
      q_n    = '0;
    end else if (busy_q) begin
      if (q_q == TIP_C) begin
        busy_n = 1'b0;
        if (!s_lvl) begin
          val_n  = 1'b1;
          lock_n = LS_LOCK;
          lc_n   = ACC_LC;
        end else if (expire) begin
          lock_n = LS_ACQ;
        end
      end else begin
        q_n = q_q + 1'b1;
      end
    end else if (s_fall && win) begin
      busy_n = 1'b1;
      q_n    = QW'(1);
    end else if (expire) begin
      lock_n = LS_ACQ;
    end

    g1_n = en && ((lock_n == LS_ACQ) || (lc_n >= a_v && lc_n < e_v));
    g2_n = ~busy_n;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      lock_q <= LS_ACQ;
      lc_q   <= '0;
      busy_q <= 1'b0;
      q_q    <= '0;
      g1_q   <= 1'b1;
      g2_q   <= 1'b1;
      val_q  <= 1'b0;
    end else begin
      lock_q <= lock_n;
      lc_q   <= lc_n;
      busy_q <= busy_n;
      q_q    <= q_n;
      g1_q   <= g1_n;
      g2_q   <= g2_n;
      val_q  <= val_n;
    end
  end

  assign gate1 = g1_q;
  assign gate2 = g2_q;
  assign valid = val_q;

  // R6: strobe lasts one cycle
  p_valid_pulse_r6: assert property (@(posedge clk) disable iff (rst)
    valid |=> !valid);
  // R6: an accepted tip coincides with the end of the width test
  p_valid_at_gate2_end_r6: assert property (@(posedge clk) disable iff (rst)
    $rose(valid) |-> $rose(gate2));
  // R6: the window is closed right after a new line reference
  p_valid_closes_window_r6: assert property (@(posedge clk) disable iff (rst)
    valid |-> !gate1);
  // R1: no window and no test in pass-through
  p_gates_idle_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (!gate1 && gate2 && !valid));

endmodule

// File: rtl/csv_pulse.sv
module csv_pulse #(
  parameter int CLAMP_DLY = 8,
  parameter int CLAMP_W   = 54,
  parameter int PCW       = 6
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic s_lvl,
  input  logic s_rise,
  input  logic valid,
  output logic clamp
);

  localparam logic [PCW-1:0] P_ON  = PCW'(CLAMP_DLY + 1);
  localparam logic [PCW-1:0] P_END = PCW'(CLAMP_DLY + CLAMP_W);

  logic [PCW-1:0] pc_q, pc_n;
  logic           arm_q, arm_n, clamp_q, clamp_n, armed;

  always_comb begin
    armed = arm_q | valid;
    arm_n = armed;
    pc_n  = pc_q;
    if (!en) begin
      arm_n   = 1'b0;
      pc_n    = '0;
      clamp_n = s_lvl;
    end else begin
      if (armed && s_rise) begin
        arm_n = 1'b0;
        pc_n  = PCW'(1);
      end else if (pc_q != '0) begin
        pc_n = (pc_q == P_END) ? '0 : pc_q + 1'b1;
      end
      clamp_n = (pc_n >= P_ON) && (pc_n <= P_END);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      arm_q   <= 1'b0;
      clamp_q <= 1'b0;
    end else begin
      pc_q    <= pc_n;
      arm_q   <= arm_n;
      clamp_q <= clamp_n;
    end
  end

  assign clamp = clamp_q;

  logic           en_d;
  logic [PCW-1:0] run_q;
  always_ff @(posedge clk) begin
    if (rst) begin
      en_d  <= 1'b0;
      run_q <= '0;
    end else begin
      en_d  <= en;
      run_q <= (clamp_q && en_d && en) ? run_q + 1'b1 : '0;
    end
  end

  // R7: an internal clamp pulse never outlasts its width
  p_clamp_run_r7: assert property (@(posedge clk) disable iff (rst)
    run_q <= PCW'(CLAMP_W));
  // R1: pass-through copies the synchronized level
  p_pass_r1: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && !$past(en)) |-> (clamp == $past(s_lvl)));

endmodule

// File: rtl/csync_clamp_gen.sv
module csync_clamp_gen
  import csv_pkg::*;
#(
  parameter int A_NTSC      = 867,
  parameter int B_NTSC      = 43,
  parameter int A_PAL       = 1075,
  parameter int B_PAL       = 61,
  parameter int TIP_W       = 58,
  parameter int CLAMP_W     = 54,
  parameter int CLAMP_DLY   = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic clamp_en,
  input  logic std_pal,
  input  logic sync_in,
  output logic clamp_out,
  output logic gate1,
  output logic gate2,
  output logic sync_valid
);

  localparam int WMAX = csv_max(A_NTSC + B_NTSC, A_PAL + B_PAL);
  localparam int LCW  = $clog2(WMAX + TIP_W + 2);
  localparam int QW   = $clog2(TIP_W + 1);
  localparam int PCW  = $clog2(CLAMP_DLY + CLAMP_W + 1);

  logic s_lvl, s_fall, s_rise, valid_w;

  csv_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .din(sync_in),
    .s_lvl(s_lvl), .s_fall(s_fall), .s_rise(s_rise)
  );

  csv_line #(
    .A_NTSC(A_NTSC), .B_NTSC(B_NTSC), .A_PAL(A_PAL), .B_PAL(B_PAL),
    .TIP_W(TIP_W), .LCW(LCW), .QW(QW)
  ) u_line (
    .clk(clk), .rst(rst), .en(clamp_en), .pal(std_pal),
    .s_lvl(s_lvl), .s_fall(s_fall),
    .gate1(gate1), .gate2(gate2), .valid(valid_w)
  );

  csv_pulse #(.CLAMP_DLY(CLAMP_DLY), .CLAMP_W(CLAMP_W), .PCW(PCW)) u_pulse (
    .clk(clk), .rst(rst), .en(clamp_en), .s_lvl(s_lvl), .s_rise(s_rise),
    .valid(valid_w), .clamp(clamp_out)
  );

  assign sync_valid = valid_w;

endmodule

// File: tb/test_csync_clamp_gen.sv
`timescale 1ns/1ps
module test_csync_clamp_gen;

  localparam int D = 8;

  logic clk = 1'b0;
  logic rst = 1'b1, clamp_en = 1'b1, std_pal = 1'b0, sync_in = 1'b1;
  logic clamp_out, gate1, gate2, sync_valid;

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  csync_clamp_gen i_csync_clamp_gen (
    .clk(clk), .rst(rst), .clamp_en(clamp_en), .std_pal(std_pal),
    .sync_in(sync_in), .clamp_out(clamp_out), .gate1(gate1),
    .gate2(gate2), .sync_valid(sync_valid)
  );

  // reference model state
  bit m1, m2, md, mlock, mbusy, marm, mval, mg1, mg2, mcl;
  int mlc, mq, mpc;
  // scenario observation
  bit g2_watch = 0, g2_seen = 0;
  int vcount = 0, pcount = 0, run = 0;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic model_step(input bit pin);
    int a, e;
    bit fall, rise, win, exp_l;
    bit nlock, nbusy, narm, nval;
    int nlc, nq, npc;
    if (rst) begin
      m1 = 1; m2 = 1; md = 1; mlock = 0; mbusy = 0; marm = 0; mval = 0;
      mg1 = 1; mg2 = 1; mcl = 0; mlc = 0; mq = 0; mpc = 0;
      return;
    end
    a = std_pal ? 1075 : 867;
    e = std_pal ? 1136 : 910;
    fall = md && !m2;
    rise = !md && m2;
    if (!clamp_en) begin
      mlock = 0; mlc = 0; mbusy = 0; mq = 0; mval = 0; marm = 0; mpc = 0;
      mg1 = 0; mg2 = 1; mcl = m2;
    end else begin
      win = !mlock || (mlc >= a && mlc < e);
      exp_l = mlock && (mlc + 1 >= e);
      nlock = mlock; nlc = mlc + 1; nbusy = mbusy; nq = mq; nval = 0; narm = marm;
      if (mbusy) begin
        if (mq == 58) begin
          nbusy = 0;
          if (!m2) begin nval = 1; nlock = 1; nlc = 59; narm = 1; end
          else if (exp_l) nlock = 0;
        end else nq = mq + 1;
      end else if (fall && win) begin
        nbusy = 1; nq = 1;
      end else if (exp_l) nlock = 0;
      npc = mpc;
      if (marm && rise) begin narm = 0; npc = 1; end
      else if (mpc > 0) npc = (mpc == D + 54) ? 0 : mpc + 1;
      mlock = nlock; mlc = nlc; mbusy = nbusy; mq = nq; mval = nval;
      marm = narm; mpc = npc;
      mg1 = !mlock || (mlc >= a && mlc < e);
      mg2 = !mbusy;
      mcl = (mpc >= D + 1) && (mpc <= D + 54);
    end
    md = m2; m2 = m1; m1 = pin;
  endtask

  task automatic compare();
    check(clamp_out === mcl, clamp_en ? "R7 clamp_out" : "R1 clamp_out", clamp_out, mcl);
    check(gate1 === mg1, "R3 gate1", gate1, mg1);
    check(gate2 === mg2, "R5 gate2", gate2, mg2);
    check(sync_valid === mval, "R6 sync_valid", sync_valid, mval);
    if (g2_watch && !gate2) g2_seen = 1;
    if (sync_valid) vcount++;
    if (clamp_en && clamp_out) run++;
    else begin
      if (run > 0) begin
        pcount++;
        check(run == 54, "R7 pulse width", run, 54);
      end
      run = 0;
    end
  endtask

  task automatic cyc(input bit pin);
    sync_in = pin;
    model_step(pin);
    @(negedge clk);
    compare();
  endtask

  task automatic hold(input bit pin, input int n);
    for (int i = 0; i < n; i++) cyc(pin);
  endtask

  initial begin
    rst = 1; clamp_en = 1; std_pal = 0;
    hold(1, 3);
    rst = 0;
    check(gate1 === 1'b1 && gate2 === 1'b1, "R9 reset gates", {gate1, gate2}, 3);
    check(clamp_out === 1'b0 && sync_valid === 1'b0, "R9 reset outputs",
          {clamp_out, sync_valid}, 0);

    // NTSC: short glitch in acquisition, then five lines at 880
    hold(1, 20);
    hold(0, 20); hold(1, 100);
    hold(0, 70); hold(1, 810);
    hold(0, 70); hold(1, 430);
    g2_watch = 1; g2_seen = 0;
    hold(0, 5); hold(1, 375);
    g2_watch = 0;
    check(g2_seen == 0, "R4 early edge ignored", g2_seen, 0);
    hold(0, 70); hold(1, 810);
    hold(0, 70); hold(1, 810);
    hold(0, 70); hold(1, 1200);
    check(gate1 === 1'b1, "R8 back in acquisition", gate1, 1);
    hold(0, 70); hold(1, 810);
    hold(0, 30); hold(1, 300);
    check(vcount == 6, "R6 NTSC accepted tips", vcount, 6);
    check(pcount == 6, "R7 NTSC clamp pulses", pcount, 6);

    // pass-through with latency check
    clamp_en = 0;
    hold(0, 20);
    cyc(1); cyc(1);
    check(clamp_out === 1'b0, "R2 latency not yet", clamp_out, 0);
    cyc(1);
    check(clamp_out === 1'b1, "R2 latency three edges", clamp_out, 1);
    check(gate1 === 1'b0 && gate2 === 1'b1, "R1 gates idle", {gate1, gate2}, 1);
    hold(1, 30); hold(0, 20);

    // PAL: four lines at 1090, then a short tip in the window
    clamp_en = 1; std_pal = 1; vcount = 0; pcount = 0;
    hold(1, 100);
    for (int k = 0; k < 4; k++) begin hold(0, 70); hold(1, 1020); end
    hold(0, 10); hold(1, 300);
    check(vcount == 4, "R6 PAL accepted tips", vcount, 4);
    check(pcount == 4, "R7 PAL clamp pulses", pcount, 4);
    check(gate1 === 1'b1, "R8 PAL lock dropped", gate1, 1);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

endmodule